// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vectoring Unit

This unit selects, each clock, the one interrupt source that should be serviced next and tells the CPU how to reach its handler. The candidates are an undefined-opcode trap, a non-maskable input, a vectored group input, and a fixed list of assigned-vector sources. The vectored group input is the OR of an external pin and the on-chip peripherals that supply their own vectors. The assigned-vector list holds three external maskable inputs and eight on-chip peripheral requests.

An assigned-vector source gets a 32-bit table-entry address. That address is joined from an extend value, a base field and a vector constant that is fixed for each source. The non-maskable input gets a fixed restart address. The trap gets a parameterised address. The vectored group gets no address, because its vector is fetched over the daisy chain outside this block.

The unit also holds the two interrupt-enable flags. When the CPU pulses accept, the selection is frozen until the CPU signals that the acknowledge has ended. For assigned-vector sources, an I/O-request-only acknowledge indication is raised during that time.

Top module: `irq_vector_unit`

## Requirements
- R1: Priority, highest first, with the `src_o` code in brackets: trap (0), non-maskable (1), vectored group (2), int1 (3), int2 (4), `periph_i[0]`..`periph_i[7]` (5..12), int3 (13). With no eligible source and no held selection, `valid_o`=0 and `src_o`=15.
- R2: The vectored group and all assigned-vector sources are eligible only while IEF1 is set. Trap and non-maskable are eligible whatever the flags hold.
- R3: Assigned vectors, in priority order starting at int1, are 00h, 04h, 08h, 0Ch, 10h, 18h, 1Ch, 20h, 24h, 28h, 2Ch. Slot 14h is never produced.
- R4: An assigned-vector address is {`vec_ext_i`[15:0], `vec_base_i`[6:0], vector[8:0]}. Bit 0 of every address driven while `valid_o` is high is 0.
- R5: A falling edge on `nmi_n_i` is latched. It stays pending after the pin returns high and until it is accepted. Its target address is 0000_0066h.
- R6: A one-cycle `trap_i` strobe stays pending until it is accepted. It is unmaskable and works from the first cycle after reset. Its target address is 0.
- R7: The vectored group request is `int0_pin_i` OR any bit of `int0_periph_i`. Its target address is 0.
- R8: Reset clears both enable flags. `ief_set_i` sets both and `ief_clr_i` clears both, with clear winning over set. Accepting a vectored-group or assigned-vector source clears both flags, and this has precedence over the two controls. Trap and non-maskable acceptance leave the flags unchanged.
- R9: `ack_iorq_o` is high exactly while an accepted assigned-vector source is held.
- R10: Requests are registered once per clock. `accept_i` takes the current winner when nothing is held. Source and address then stay fixed until the clock edge that sees `ack_done_i`, after which arbitration resumes.
- R11: Just after reset: `valid_o`=0, `src_o`=15, `target_addr_o`=0, `ack_iorq_o`=0, `busy_o`=0, `ief1_o`=0, `ief2_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Undefined-opcode trap strobe |
| nmi_n_i | input | 1 | Non-maskable request, active on falling edge |
| int0_pin_i | input | 1 | External vectored-group request |
| int0_periph_i | input | 4 | Vectoring peripheral requests (ORed into group) |
| int1_i | input | 1 | External maskable request 1 |
| int2_i | input | 1 | External maskable request 2 |
| int3_i | input | 1 | External maskable request 3 |
| periph_i | input | 8 | Assigned-vector peripheral requests, bit 0 highest |
| vec_ext_i | input | 16 | Table address bits 31..16 |
| vec_base_i | input | 7 | Table address bits 15..9 |
| ief_set_i | input | 1 | Set both enable flags |
| ief_clr_i | input | 1 | Clear both enable flags |
| accept_i | input | 1 | CPU takes the current winner |
| ack_done_i | input | 1 | CPU has completed the acknowledge |
| valid_o | output | 1 | A selection is offered or held |
| src_o | output | 4 | Selected source code |
| target_addr_o | output | 32 | Restart or table-entry address |
| ack_iorq_o | output | 1 | I/O-request-only acknowledge indication |
| busy_o | output | 1 | Selection held between accept and completion |
| ief1_o | output | 1 | Enable flag 1 |
| ief2_o | output | 1 | Enable flag 2 |

## Verification
A request level, the enable controls and a trap strobe driven before a clock edge show up in the outputs one clock later. A falling edge on the non-maskable pin is also visible one clock later. Accept and completion change `busy_o`, `ack_iorq_o` and the flags one clock later. The extend and base inputs reach the unheld address with no delay. The bench drives its inputs one time unit after the falling edge. It advances its reference model on the rising edge and compares at the next falling edge, so every result is checked exactly one cycle after the stimulus that causes it.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int SRC_TRAP = 0;
   localparam int SRC_NMI  = 1;
   localparam int SRC_GRP  = 2;
   localparam int SRC_ASG0 = 3;
   localparam logic [3:0] SRC_NONE = 4'hF;

   // vector of assigned slot k: skips the reserved slot position
   function automatic int unsigned slot_vector(int unsigned k, int unsigned step,
                                               int unsigned rsvd);
      return (k + ((k >= rsvd) ? 1 : 0)) * step;
   endfunction
endpackage

// File: rtl/irqv_pend_latch.sv
module irqv_pend_latch #(
   parameter bit FALL_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   input  logic clr_i,
   output logic pend_o
);
   logic set_w;

   generate
      if (FALL_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= in_i;
         end
         assign set_w = prev_q & ~in_i;

         a_r5_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_q && !in_i) |=> pend_o);
      end else begin : g_strobe
         assign set_w = in_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pend_o <= 1'b0;
      else        pend_o <= (pend_o & ~clr_i) | set_w;
   end

   a_r5_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/irqv_prio_arb.sv
module irqv_prio_arb #(
   parameter int N     = 14,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   initial begin
      assert (N < (1 << IDX_W)) else $error("index width too small");
   end

   // bit 0 is the highest priority: scan downwards so the lowest set bit wins
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqv_addr_form.sv
module irqv_addr_form import irqv_pkg::*; #(
   parameter int N_ASG     = 11,
   parameter int ASG_W     = 4,
   parameter int EXT_W     = 16,
   parameter int BASE_W    = 7,
   parameter int VEC_W     = 9,
   parameter int VEC_STEP  = 4,
   parameter int RSVD_SLOT = 5
) (
   input  logic [ASG_W-1:0]               idx_i,
   input  logic [EXT_W-1:0]               ext_i,
   input  logic [BASE_W-1:0]              base_i,
   output logic [EXT_W+BASE_W+VEC_W-1:0]  addr_o
);
   localparam int TOP_VEC = slot_vector(N_ASG - 1, VEC_STEP, RSVD_SLOT);

   initial begin
      assert (VEC_STEP % 2 == 0) else $error("vector step must keep addresses even");
      assert (TOP_VEC < (1 << VEC_W)) else $error("vectors overflow the vector field");
   end

   logic [VEC_W-1:0] vtab [N_ASG];
   logic [VEC_W-1:0] vec;

   genvar g;
   generate
      for (g = 0; g < N_ASG; g++) begin : g_vtab
         assign vtab[g] = VEC_W'(slot_vector(g, VEC_STEP, RSVD_SLOT));
      end
   endgenerate

   always_comb begin
      vec = '0;
      for (int i = 0; i < N_ASG; i++) begin
         if (idx_i == ASG_W'(i)) vec = vtab[i];
      end
   end

   assign addr_o = {ext_i, base_i, vec};
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit import irqv_pkg::*; #(
   parameter int          N_PERIPH  = 8,
   parameter int          N_VPERIPH = 4,
   parameter int          EXT_W     = 16,
   parameter int          BASE_W    = 7,
   parameter int          VEC_W     = 9,
   parameter int          VEC_STEP  = 4,
   parameter int          RSVD_SLOT = 5,
   parameter logic [31:0] NMI_ADDR  = 32'h0000_0066,
   parameter logic [31:0] TRAP_ADDR = 32'h0000_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trap_i,
   input  logic                 nmi_n_i,
   input  logic                 int0_pin_i,
   input  logic [N_VPERIPH-1:0] int0_periph_i,
   input  logic                 int1_i,
   input  logic                 int2_i,
   input  logic                 int3_i,
   input  logic [N_PERIPH-1:0]  periph_i,
   input  logic [EXT_W-1:0]     vec_ext_i,
   input  logic [BASE_W-1:0]    vec_base_i,
   input  logic                 ief_set_i,
   input  logic                 ief_clr_i,
   input  logic                 accept_i,
   input  logic                 ack_done_i,
   output logic                 valid_o,
   output logic [3:0]           src_o,
   output logic [31:0]          target_addr_o,
   output logic                 ack_iorq_o,
   output logic                 busy_o,
   output logic                 ief1_o,
   output logic                 ief2_o
);
   localparam int N_ASG  = N_PERIPH + 3;
   localparam int N_SRC  = N_ASG + SRC_ASG0;
   localparam int SRC_W  = 4;
   localparam int ASG_W  = $clog2(N_ASG);
   localparam int ADDR_W = EXT_W + BASE_W + VEC_W;

   initial begin
      assert (ADDR_W == 32) else $error("address fields must total 32 bits");
      assert (N_SRC < 15) else $error("too many sources for the 4-bit code");
   end

   // ---------------- request sampling ----------------
   logic             grp_q;
   logic [N_ASG-1:0] asg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= 1'b0;
         asg_q <= '0;
      end else begin
         grp_q <= int0_pin_i | (|int0_periph_i);
         asg_q <= {int3_i, periph_i, int2_i, int1_i};
      end
   end

   // ---------------- pending latches ----------------
   logic trap_pend, nmi_pend, trap_clr, nmi_clr;

   irqv_pend_latch #(.FALL_EDGE(1'b0)) u_trap (
      .clk(clk), .rst_n(rst_n), .in_i(trap_i), .clr_i(trap_clr), .pend_o(trap_pend));

   irqv_pend_latch #(.FALL_EDGE(1'b1)) u_nmi (
      .clk(clk), .rst_n(rst_n), .in_i(nmi_n_i), .clr_i(nmi_clr), .pend_o(nmi_pend));

   // ---------------- arbitration ----------------
   logic             ief1_q, ief2_q;
   logic [N_SRC-1:0] elig;
   logic             any;
   logic [SRC_W-1:0] gnt;

   assign elig = {asg_q & {N_ASG{ief1_q}}, grp_q & ief1_q, nmi_pend, trap_pend};

   irqv_prio_arb #(.N(N_SRC), .IDX_W(SRC_W)) u_arb (
      .req_i(elig), .any_o(any), .idx_o(gnt));

   // ---------------- address formation ----------------
   logic [SRC_W-1:0]  asg_off;
   logic [ADDR_W-1:0] asg_addr;
   logic [31:0]       win_addr;

   assign asg_off = gnt - SRC_W'(SRC_ASG0);

   irqv_addr_form #(
      .N_ASG(N_ASG), .ASG_W(ASG_W), .EXT_W(EXT_W), .BASE_W(BASE_W),
      .VEC_W(VEC_W), .VEC_STEP(VEC_STEP), .RSVD_SLOT(RSVD_SLOT)
   ) u_addr (
      .idx_i(asg_off[ASG_W-1:0]), .ext_i(vec_ext_i), .base_i(vec_base_i), .addr_o(asg_addr));

   always_comb begin
      case (gnt)
         SRC_W'(SRC_TRAP): win_addr = TRAP_ADDR;
         SRC_W'(SRC_NMI):  win_addr = NMI_ADDR;
         SRC_W'(SRC_GRP):  win_addr = '0;
         default:          win_addr = asg_addr;
      endcase
   end

   // ---------------- accept / hold ----------------
   logic             take, take_mask;
   logic             busy_q;
   logic [SRC_W-1:0] hsrc_q;
   logic [31:0]      haddr_q;

   assign take      = accept_i & ~busy_q & any;
   assign take_mask = take & (gnt >= SRC_W'(SRC_GRP));
   assign trap_clr  = take & (gnt == SRC_W'(SRC_TRAP));
   assign nmi_clr   = take & (gnt == SRC_W'(SRC_NMI));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         hsrc_q  <= SRC_NONE;
         haddr_q <= '0;
      end else if (busy_q) begin
         if (ack_done_i) busy_q <= 1'b0;
      end else if (take) begin
         busy_q  <= 1'b1;
         hsrc_q  <= gnt;
         haddr_q <= win_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ief1_q <= 1'b0;
         ief2_q <= 1'b0;
      end else if (take_mask || ief_clr_i) begin
         ief1_q <= 1'b0;
         ief2_q <= 1'b0;
      end else if (ief_set_i) begin
         ief1_q <= 1'b1;
         ief2_q <= 1'b1;
      end
   end

   // ---------------- outputs ----------------
   assign valid_o       = busy_q | any;
   assign src_o         = busy_q ? hsrc_q  : (any ? gnt : SRC_NONE);
   assign target_addr_o = busy_q ? haddr_q : (any ? win_addr : 32'h0);
   assign ack_iorq_o    = busy_q & (hsrc_q >= SRC_W'(SRC_ASG0));
   assign busy_o        = busy_q;
   assign ief1_o        = ief1_q;
   assign ief2_o        = ief2_q;

   // ---------------- assertions ----------------
   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !ack_done_i) |=> ($stable(src_o) && $stable(target_addr_o) && busy_o));

   a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && !busy_o && valid_o && src_o >= 4'd2) |=> (!ief1_o && !ief2_o));

   a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !ief1_o && valid_o) |-> (src_o < 4'd2));

   a_r9_iorq_only_held: assert property (@(posedge clk) disable iff (!rst_n)
      ack_iorq_o |-> (busy_o && src_o >= 4'd3));

   a_r5_nmi_target: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && src_o == 4'd1) |-> (target_addr_o == NMI_ADDR));

   a_r4_even: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !target_addr_o[0]);
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_i = 0, nmi_n_i = 1, int0_pin_i = 0;
   logic [3:0]  int0_periph_i = '0;
   logic        int1_i = 0, int2_i = 0, int3_i = 0;
   logic [7:0]  periph_i = '0;
   logic [15:0] vec_ext_i = 16'hABCD;
   logic [6:0]  vec_base_i = 7'h5A;
   logic        ief_set_i = 0, ief_clr_i = 0, accept_i = 0, ack_done_i = 0;
   logic        valid_o, ack_iorq_o, busy_o, ief1_o, ief2_o;
   logic [3:0]  src_o;
   logic [31:0] target_addr_o;

   irq_vector_unit u_irq_vector_unit (
      .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .nmi_n_i(nmi_n_i),
      .int0_pin_i(int0_pin_i), .int0_periph_i(int0_periph_i),
      .int1_i(int1_i), .int2_i(int2_i), .int3_i(int3_i), .periph_i(periph_i),
      .vec_ext_i(vec_ext_i), .vec_base_i(vec_base_i),
      .ief_set_i(ief_set_i), .ief_clr_i(ief_clr_i),
      .accept_i(accept_i), .ack_done_i(ack_done_i),
      .valid_o(valid_o), .src_o(src_o), .target_addr_o(target_addr_o),
      .ack_iorq_o(ack_iorq_o), .busy_o(busy_o), .ief1_o(ief1_o), .ief2_o(ief2_o));

   always #5 clk = ~clk;

   int checks = 0, fails = 0;
   bit model_on = 0;

   // ---------------- reference model ----------------
   int m_trap, m_nmi, m_prev, m_ief, m_busy, m_hsrc;
   logic [31:0] m_haddr;
   int m_req[14];
   int vtab[11] = '{0, 4, 8, 12, 16, 24, 28, 32, 36, 40, 44};

   function automatic int winner();
      if (m_trap != 0) return 0;
      if (m_nmi != 0) return 1;
      if (m_ief != 0)
         for (int s = 2; s < 14; s++) if (m_req[s] != 0) return s;
      return -1;
   endfunction

   function automatic logic [31:0] addr_of(int s);
      if (s == 0) return 32'h0;
      if (s == 1) return 32'h66;
      if (s == 2) return 32'h0;
      return {vec_ext_i, vec_base_i, 9'(vtab[s-3])};
   endfunction

   always @(posedge clk) begin
      int w;
      bit acc;
      if (!rst_n) begin
         m_trap = 0; m_nmi = 0; m_prev = 1; m_ief = 0; m_busy = 0; m_hsrc = 15;
         m_haddr = 0;
         for (int s = 0; s < 14; s++) m_req[s] = 0;
      end else begin
         w = winner();
         acc = (m_busy == 0) && accept_i && (w >= 0);
         if (m_busy != 0) begin
            if (ack_done_i) m_busy = 0;
         end else if (acc) begin
            m_busy = 1; m_hsrc = w; m_haddr = addr_of(w);
         end
         m_trap = ((m_trap != 0 && !(acc && w == 0)) || trap_i) ? 1 : 0;
         m_nmi  = ((m_nmi != 0 && !(acc && w == 1)) || (m_prev != 0 && !nmi_n_i)) ? 1 : 0;
         m_prev = nmi_n_i ? 1 : 0;
         if (acc && w >= 2) m_ief = 0;
         else if (ief_clr_i) m_ief = 0;
         else if (ief_set_i) m_ief = 1;
         m_req[2]  = (int0_pin_i || (|int0_periph_i)) ? 1 : 0;
         m_req[3]  = int1_i ? 1 : 0;
         m_req[4]  = int2_i ? 1 : 0;
         for (int p = 0; p < 8; p++) m_req[5+p] = periph_i[p] ? 1 : 0;
         m_req[13] = int3_i ? 1 : 0;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      int w;
      logic [3:0] e_src;
      logic [31:0] e_addr;
      logic e_valid, e_iorq;
      if (m_busy != 0) begin
         e_valid = 1; e_src = 4'(m_hsrc); e_addr = m_haddr; e_iorq = (m_hsrc >= 3);
      end else begin
         w = winner();
         e_valid = (w >= 0);
         e_src = (w >= 0) ? 4'(w) : 4'hF;
         e_addr = (w >= 0) ? addr_of(w) : 32'h0;
         e_iorq = 0;
      end
      chk("R1 model valid", {31'b0, valid_o}, {31'b0, e_valid});
      chk("R1 model src", {28'b0, src_o}, {28'b0, e_src});
      chk("R4 model addr", target_addr_o, e_addr);
      chk("R9 model iorq", {31'b0, ack_iorq_o}, {31'b0, e_iorq});
      chk("R10 model busy", {31'b0, busy_o}, 32'(m_busy));
      chk("R8 model ief", {30'b0, ief1_o, ief2_o}, {30'b0, m_ief[0], m_ief[0]});
   endtask

   task automatic cyc();
      @(negedge clk);
      if (model_on) compare_model();
      #1;
   endtask

   task automatic clear_reqs();
      int1_i = 0; int2_i = 0; int3_i = 0; periph_i = '0;
      int0_pin_i = 0; int0_periph_i = '0;
   endtask

   task automatic set_slot(int k);
      clear_reqs();
      if (k == 0) int1_i = 1;
      else if (k == 1) int2_i = 1;
      else if (k == 10) int3_i = 1;
      else periph_i[k-2] = 1;
   endtask

   task automatic accept_and_finish();
      accept_i = 1; cyc(); accept_i = 0;
      ack_done_i = 1; cyc(); ack_done_i = 0;
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      model_on = 1;
      cyc();
      // R11 reset state
      chk("R11 valid", {31'b0, valid_o}, 0);
      chk("R11 src", {28'b0, src_o}, 32'hF);
      chk("R11 addr", target_addr_o, 0);
      chk("R11 iorq/busy", {30'b0, ack_iorq_o, busy_o}, 0);
      chk("R11 ief", {30'b0, ief1_o, ief2_o}, 0);

      // R2: maskable ignored while flags clear
      int1_i = 1; cyc();
      chk("R2 masked int1", {31'b0, valid_o}, 0);
      ief_set_i = 1; cyc(); ief_set_i = 0;
      chk("R8 ief set", {30'b0, ief1_o, ief2_o}, 32'h3);
      chk("R1 int1 wins", {28'b0, src_o}, 3);
      chk("R4 int1 addr", target_addr_o, 32'hABCD_B400);

      // R1 ordering among assigned sources
      int1_i = 0; int2_i = 1; periph_i[7] = 1; int3_i = 1; cyc();
      chk("R1 int2 over mailbox/int3", {28'b0, src_o}, 4);
      chk("R3 int2 vector", target_addr_o, 32'hABCD_B404);

      // R9/R10/R8 accept and hold
      accept_i = 1; cyc(); accept_i = 0;
      chk("R10 busy", {31'b0, busy_o}, 1);
      chk("R9 iorq held", {31'b0, ack_iorq_o}, 1);
      chk("R8 cleared by accept", {30'b0, ief1_o, ief2_o}, 0);
      int2_i = 0; vec_ext_i = 16'h1111; cyc();
      chk("R10 src held", {28'b0, src_o}, 4);
      chk("R10 addr held", target_addr_o, 32'hABCD_B404);
      vec_ext_i = 16'hABCD;
      ack_done_i = 1; cyc(); ack_done_i = 0;
      chk("R10 released", {31'b0, busy_o}, 0);
      chk("R2 masked after accept", {31'b0, valid_o}, 0);

      // R3: every assigned slot
      ief_set_i = 1; cyc(); ief_set_i = 0;
      for (int k = 0; k < 11; k++) begin
         set_slot(k); cyc();
         chk("R3 slot src", {28'b0, src_o}, 32'(3 + k));
         chk("R3 slot vector", target_addr_o, {16'hABCD, 7'h5A, 9'(vtab[k])});
      end

      // R7: group request
      clear_reqs(); int1_i = 1; int0_periph_i[2] = 1; cyc();
      chk("R7 group via peripheral", {28'b0, src_o}, 2);
      chk("R7 group addr", target_addr_o, 0);
      int0_periph_i = '0; int0_pin_i = 1; cyc();
      chk("R7 group via pin", {28'b0, src_o}, 2);

      // R5: non-maskable edge latched
      nmi_n_i = 0; cyc(); nmi_n_i = 1;
      chk("R5 nmi wins", {28'b0, src_o}, 1);
      chk("R5 nmi addr", target_addr_o, 32'h66);
      cyc();
      chk("R5 nmi still pending", {28'b0, src_o}, 1);
      accept_i = 1; cyc(); accept_i = 0;
      chk("R9 no iorq for nmi", {31'b0, ack_iorq_o}, 0);
      chk("R8 nmi keeps flags", {31'b0, ief1_o}, 1);
      ack_done_i = 1; cyc(); ack_done_i = 0;
      chk("R5 nmi consumed", {28'b0, src_o}, 2);

      // R6: trap unmaskable, beats nmi
      ief_clr_i = 1; cyc(); ief_clr_i = 0;
      trap_i = 1; nmi_n_i = 0; cyc(); trap_i = 0; nmi_n_i = 1;
      chk("R6 trap wins", {28'b0, src_o}, 0);
      chk("R6 trap addr", target_addr_o, 0);
      accept_and_finish();
      chk("R6 then nmi", {28'b0, src_o}, 1);
      accept_and_finish();
      chk("R2 none left", {31'b0, valid_o}, 0);
      clear_reqs();

      // random phase against the model
      for (int n = 0; n < 3000; n++) begin
         int1_i = ($urandom % 6) == 0;
         int2_i = ($urandom % 6) == 0;
         int3_i = ($urandom % 6) == 0;
         for (int p = 0; p < 8; p++) periph_i[p] = ($urandom % 8) == 0;
         int0_pin_i = ($urandom % 10) == 0;
         int0_periph_i = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
         trap_i = ($urandom % 60) == 0;
         if ($urandom % 20 == 0) nmi_n_i = ~nmi_n_i;
         ief_set_i = ($urandom % 5) == 0;
         ief_clr_i = ($urandom % 15) == 0;
         accept_i = ($urandom % 3) == 0;
         ack_done_i = ($urandom % 3) == 0;
         if ($urandom % 25 == 0) vec_ext_i = 16'($urandom);
         if ($urandom % 25 == 0) vec_base_i = 7'($urandom);
         cyc();
      end

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule